// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the slave-side protocol engine of a byte-addressed serial memory attached to a two-wire open-drain bus. It oversamples the clock and data lines with a fast system clock and recognises bus start and stop conditions. It shifts bytes in most significant bit first and answers a device-select byte whose upper nibble names one of two device types: the main 16384-byte array or a 64-byte identification page. The low three select bits must equal the strapped address pins.

After a write select, two word-address bytes load an internal address counter. Only the low 14 bits of that address are kept. Each following data byte is handed to the storage interface as a one-cycle write strobe and then advances the counter inside its 64-byte page. A stop condition that ends a write carrying data raises a single commit pulse for the external write-commit unit. That unit reports its self-timed programming through a busy input. While busy is high the engine does not acknowledge its own select byte, so a master can poll for completion.

A read select streams bytes from the counter for as long as the master acknowledges. The counter keeps its value between transactions, which gives current-address reads, random reads (a dummy write followed by a repeated start) and sequential reads.

Top module: `tw_mem_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. After a stop, bytes clocked without a new start are never acknowledged.
- R2: The select byte is {type[3:0], pins[2:0], rw}. Type 4'b1010 selects the main array and 4'b1011 selects the identification page, and pins must equal strap_i. On a match the engine pulls data low during the ninth clock. On any mismatch it does not acknowledge, and it stays silent until the next start or stop.
- R3: After a write select, the engine acknowledges a high address byte and a low address byte, and the word address becomes {high[5:0], low}. It acknowledges every data byte that follows.
- R4: Each data byte written produces a one-cycle mem_we_o with mem_addr_o and mem_wdata_o. Successive bytes advance only the low 6 address bits, wrapping inside the 64-byte page.
- R5: A stop that ends a write carrying at least one data byte gives exactly one commit_o pulse. A write with no data byte gives none.
- R6: While busy_i is high when a select byte completes, that select is not acknowledged. Once busy_i falls, the same select is acknowledged again.
- R7: Read data leaves most significant bit first. A random read returns the stored byte at the loaded address, and the data line is changed only while the clock line is low.
- R8: During a read, the engine sends the next byte after every master acknowledge. After a master no-acknowledge it releases the line and drives nothing until the next start or stop.
- R9: A main-array read that passes address 16383 continues at address 0.
- R10: A current-address read returns the byte after the last byte accessed, whether that access was a read or a page-wrapped write.
- R11: Accesses with type 4'b1011 assert mem_id_o. Their reads and writes wrap inside the 64-byte page, and they leave the main array untouched.
- R12: Out of reset the line is released and neither mem_we_o nor commit_o is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Strapped device address pins |
| busy_i | input | 1 | Self-timed write in progress |
| mem_addr_o | output | 14 | Storage address (read and write) |
| mem_id_o | output | 1 | Access targets identification page |
| mem_rdata_i | input | 8 | Storage read data at mem_addr_o |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| commit_o | output | 1 | Start self-timed programming |

## Verification
The hardest case to reach is a select byte that lands while busy_i is still high. The bench models the write-commit unit itself: each commit pulse raises busy_i for a fixed span. Right after a write's stop, the bench starts polling, so the first poll lands inside that span and is refused, and later polls must be acknowledged. Page and array wrap are reached by loading addresses one or two bytes below a boundary and writing or reading past it.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } tw_phase_e;

  localparam logic [3:0] TYPE_MAIN = 4'b1010;
  localparam logic [3:0] TYPE_ID   = 4'b1011;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b1;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign q_o      = chain_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  always_comb begin
    start_o = scl_s & scl_p & sda_p & ~sda_s;
    stop_o  = scl_s & scl_p & ~sda_p & sda_s;
    rise_o  = scl_s & ~scl_p;
    fall_o  = ~scl_s & scl_p;
  end
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic              wrap_page_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [PAGE_W-1:0] low_inc;

  always_comb begin
    low_inc = addr_q[PAGE_W-1:0] + 1'b1;
    addr_n  = addr_q;
    if (load_i) begin
      addr_n = load_val_i;
    end else if (step_i) begin
      if (wrap_page_i) addr_n = {addr_q[ADDR_W-1:PAGE_W], low_inc};
      else             addr_n = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_n;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_s_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [7:0]        rdata_i,
  output logic              sda_oe_o,
  output logic              id_o,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic              commit_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] load_val_o,
  output logic              step_o,
  output logic              wrap_page_o
);
  localparam int HI_W = ADDR_W - 8;

  tw_phase_e       phase_q, phase_n;
  logic [3:0]      cnt_q, cnt_n;
  logic [7:0]      rx_q, rx_n;
  logic [7:0]      tx_q, tx_n;
  logic [HI_W-1:0] hi_q, hi_n;
  logic            oe_q, oe_n;
  logic            id_q, id_n;
  logic            mack_q, mack_n;
  logic            dirty_q, dirty_n;
  logic            commit_q, commit_n;
  logic            sel_hit;
  logic            ack_fall, end_fall;

  always_comb begin
    sel_hit = ((rx_q[7:4] == TYPE_MAIN) || (rx_q[7:4] == TYPE_ID)) &&
              (rx_q[3:1] == strap_i) && !busy_i;
    ack_fall = fall_i && (cnt_q == 4'd8);
    end_fall = fall_i && (cnt_q == 4'd9);
  end

  always_comb begin
    phase_n  = phase_q;
    cnt_n    = cnt_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    hi_n     = hi_q;
    oe_n     = oe_q;
    id_n     = id_q;
    mack_n   = mack_q;
    dirty_n  = dirty_q;
    commit_n = 1'b0;
    load_o   = 1'b0;
    step_o   = 1'b0;
    we_o     = 1'b0;
    if (start_i) begin
      phase_n = PH_SEL;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
      dirty_n = 1'b0;
    end else if (stop_i) begin
      phase_n  = PH_IDLE;
      cnt_n    = 4'd0;
      oe_n     = 1'b0;
      commit_n = dirty_q;
      dirty_n  = 1'b0;
    end else if (rise_i) begin
      if (cnt_q != 4'd9) cnt_n = cnt_q + 4'd1;
      if (cnt_q < 4'd8)  rx_n  = {rx_q[6:0], sda_s_i};
      if (cnt_q == 4'd8) mack_n = ~sda_s_i;
    end else if (ack_fall) begin
      unique case (phase_q)
        PH_SEL: begin
          if (sel_hit) begin
            oe_n = 1'b1;
            id_n = (rx_q[7:4] == TYPE_ID);
          end else begin
            phase_n = PH_SKIP;
            oe_n    = 1'b0;
          end
        end
        PH_AHI: begin
          hi_n = rx_q[HI_W-1:0];
          oe_n = 1'b1;
        end
        PH_ALO: begin
          load_o = 1'b1;
          oe_n   = 1'b1;
        end
        PH_WDAT: begin
          we_o    = 1'b1;
          step_o  = 1'b1;
          dirty_n = 1'b1;
          oe_n    = 1'b1;
        end
        default: oe_n = 1'b0;
      endcase
    end else if (end_fall) begin
      cnt_n = 4'd0;
      oe_n  = 1'b0;
      unique case (phase_q)
        PH_SEL: begin
          if (rx_q[0]) begin
            phase_n = PH_RDAT;
            oe_n    = ~rdata_i[7];
            tx_n    = {rdata_i[6:0], 1'b0};
            step_o  = 1'b1;
          end else begin
            phase_n = PH_AHI;
          end
        end
        PH_AHI: phase_n = PH_ALO;
        PH_ALO: phase_n = PH_WDAT;
        PH_RDAT: begin
          if (mack_q) begin
            oe_n   = ~rdata_i[7];
            tx_n   = {rdata_i[6:0], 1'b0};
            step_o = 1'b1;
          end else begin
            phase_n = PH_SKIP;
          end
        end
        default: phase_n = phase_q;
      endcase
    end else if (fall_i && (phase_q == PH_RDAT) && (cnt_q != 4'd0)) begin
      oe_n = ~tx_q[7];
      tx_n = {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= 4'd0;
      rx_q     <= 8'd0;
      tx_q     <= 8'd0;
      hi_q     <= '0;
      oe_q     <= 1'b0;
      id_q     <= 1'b0;
      mack_q   <= 1'b0;
      dirty_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      cnt_q    <= cnt_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      hi_q     <= hi_n;
      oe_q     <= oe_n;
      id_q     <= id_n;
      mack_q   <= mack_n;
      dirty_q  <= dirty_n;
      commit_q <= commit_n;
    end
  end

  assign sda_oe_o    = oe_q;
  assign id_o        = id_q;
  assign wdata_o     = rx_q;
  assign commit_o    = commit_q;
  assign load_val_o  = {hi_q, rx_q};
  assign wrap_page_o = id_q | (phase_q == PH_WDAT);
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_id_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              commit_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              scl_s, scl_p, sda_s, sda_p;
  logic              start, stop, rise, fall;
  logic              ctr_load, ctr_step, ctr_wrap;
  logic [ADDR_W-1:0] ctr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tw_line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(scl_i), .q_o(scl_s), .q_prev_o(scl_p)
  );
  tw_line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(sda_i), .q_o(sda_s), .q_prev_o(sda_p)
  );

  tw_cond_detect i_cond (
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  tw_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst_n(rst_int_n),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .sda_s_i(sda_s), .strap_i(strap_i), .busy_i(busy_i), .rdata_i(mem_rdata_i),
    .sda_oe_o(sda_oe_o), .id_o(mem_id_o), .we_o(mem_we_o), .wdata_o(mem_wdata_o),
    .commit_o(commit_o), .load_o(ctr_load), .load_val_o(ctr_val),
    .step_o(ctr_step), .wrap_page_o(ctr_wrap)
  );

  tw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctr (
    .clk(clk), .rst_n(rst_int_n), .load_i(ctr_load), .load_val_i(ctr_val),
    .step_i(ctr_step), .wrap_page_i(ctr_wrap), .addr_o(mem_addr_o)
  );
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic mem_we_o,
  input logic commit_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i); // R7
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R4
  AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !scl_i); // R4
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R5
  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (scl_i && !mem_we_o)); // R5
endmodule

bind tw_mem_slave tw_mem_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .mem_we_o(mem_we_o), .commit_o(commit_o)
);

// File: tb/test_tw_mem_slave.sv
module test_tw_mem_slave;
  localparam int BUSY_CYC = 400;

  logic        clk = 1'b0;
  logic        rst_n, scl_m, sda_m, busy;
  logic [2:0]  strap;
  logic        sda_oe, mem_id, mem_we, commit;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  wire         sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  tw_mem_slave i_tw_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .busy_i(busy), .mem_addr_o(mem_addr), .mem_id_o(mem_id),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .commit_o(commit)
  );

  typedef struct { logic id; logic [13:0] a; logic [7:0] d; } wr_t;
  wr_t  exp_wr[$];
  logic [7:0] st_main[int];
  logic [7:0] ref_main[int];
  logic [7:0] st_id[64];
  logic [7:0] ref_id[64];
  int errors = 0, checks = 0, cycles = 0, commits = 0, busy_cnt = 0;
  logic [13:0] exp_ptr;

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 13) ^ (a >> 5) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] ref_get(logic id, logic [13:0] a);
    if (id) return ref_id[a[5:0]];
    if (ref_main.exists(int'(a))) return ref_main[int'(a)];
    return init_val(int'(a));
  endfunction

  function automatic logic [13:0] nxt(logic id, logic wr, logic [13:0] a);
    if (id || wr) return {a[13:6], 6'(a[5:0] + 6'd1)};
    return 14'(a + 14'd1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Reference for the storage side and the write-commit unit, every clock
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (busy_cnt > 0) busy_cnt--;
    if (rst_n && commit) begin
      commits++;
      busy_cnt = BUSY_CYC;
    end
    busy = (busy_cnt != 0);
    if (rst_n && mem_we) begin
      if (exp_wr.size() == 0) begin
        check(0, "R4 unexpected write", int'(mem_addr), 0);
      end else begin
        wr_t e;
        e = exp_wr.pop_front();
        check(e.id == mem_id, "R11 write region", int'(mem_id), int'(e.id));
        if (e.id) check(mem_addr[5:0] == e.a[5:0], "R11 id write addr", int'(mem_addr), int'(e.a));
        else      check(mem_addr == e.a, "R4 write addr", int'(mem_addr), int'(e.a));
        check(mem_wdata == e.d, "R4 write data", int'(mem_wdata), int'(e.d));
      end
      if (mem_id) st_id[mem_addr[5:0]] = mem_wdata;
      else        st_main[int'(mem_addr)] = mem_wdata;
    end
    if (mem_id) mem_rdata = st_id[mem_addr[5:0]];
    else if (st_main.exists(int'(mem_addr))) mem_rdata = st_main[int'(mem_addr)];
    else mem_rdata = init_val(int'(mem_addr));
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    wq(5); sda_m = b; wq(5); scl_m = 1'b1; wq(5); r = sda_line; wq(5); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wq(5); sda_m = 1'b1; wq(5); scl_m = 1'b1; wq(5); sda_m = 1'b0; wq(5); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(5); sda_m = 1'b0; wq(5); scl_m = 1'b1; wq(5); sda_m = 1'b1; wq(5);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(v[i], r);
    bit_x(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      v[i] = r;
    end
    bit_x(!mack, r);
  endtask

  function automatic logic [7:0] sel(logic id, logic rw);
    return {(id ? 4'b1011 : 4'b1010), strap, rw};
  endfunction

  task automatic wait_idle();
    while (busy) wq(1);
    wq(5);
  endtask

  task automatic load_addr(input logic id, input logic [13:0] a, input logic [1:0] junk, input string tag);
    logic ack;
    bus_start();
    send_byte(sel(id, 1'b0), ack); check(ack, {tag, " R2 select ack"}, ack, 1);
    send_byte({junk, a[13:8]}, ack); check(ack, "R3 high addr ack", ack, 1);
    send_byte(a[7:0], ack);          check(ack, "R3 low addr ack", ack, 1);
  endtask

  task automatic wr_seq(input logic id, input logic [13:0] a, input int n,
                        input logic [1:0] junk, input bit wait_done, input string tag);
    logic ack;
    logic [13:0] p;
    int c0;
    c0 = commits;
    load_addr(id, a, junk, tag);
    p = a;
    for (int k = 0; k < n; k++) begin
      wr_t e;
      e.id = id; e.a = p; e.d = 8'(a + k * 29 + 7);
      exp_wr.push_back(e);
      if (id) ref_id[p[5:0]] = e.d; else ref_main[int'(p)] = e.d;
      send_byte(e.d, ack); check(ack, {tag, " R3 data ack"}, ack, 1);
      p = nxt(id, 1'b1, p);
    end
    bus_stop();
    wq(10);
    check(commits == c0 + ((n > 0) ? 1 : 0), {tag, " R5 commit count"}, commits - c0, (n > 0) ? 1 : 0);
    check(exp_wr.size() == 0, {tag, " R4 writes seen"}, exp_wr.size(), 0);
    exp_ptr = p;
    if (wait_done) wait_idle();
  endtask

  task automatic rd_seq(input logic id, input logic [13:0] a, input bit rnd,
                        input int n, input string tag);
    logic ack;
    logic [7:0] v;
    logic [13:0] p;
    if (rnd) begin
      load_addr(id, a, 2'b00, tag);
      p = a;
    end else begin
      p = exp_ptr;
    end
    bus_start();
    send_byte(sel(id, 1'b1), ack); check(ack, {tag, " R2 read select ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      check(v == ref_get(id, p), tag, int'(v), int'(ref_get(id, p)));
      p = nxt(id, 1'b0, p);
    end
    recv_byte(1'b0, v);
    check(v == 8'hFF, "R8 silent after master nack", int'(v), 8'hFF);
    bus_stop();
    exp_ptr = p;
  endtask

  initial begin
    logic ack;
    int nacks;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101; busy = 1'b0;
    mem_rdata = 8'h00;
    for (int i = 0; i < 64; i++) begin
      st_id[i] = init_val(i + 1000);
      ref_id[i] = init_val(i + 1000);
    end
    wq(4);
    check(sda_oe == 1'b0, "R12 line released", sda_oe, 0);
    check(mem_we == 1'b0, "R12 no write", mem_we, 0);
    check(commit == 1'b0, "R12 no commit", commit, 0);
    rst_n = 1'b1;
    wq(10);
    check(sda_oe == 1'b0 && commit == 1'b0, "R12 after release", sda_oe, 0);
    scl_m = 1'b0;

    wr_seq(1'b0, 14'h1234, 3, 2'b00, 1'b1, "R4 byte/page write");
    rd_seq(1'b0, 14'h1234, 1'b1, 3, "R7 random+sequential read R8");
    rd_seq(1'b0, 14'h0000, 1'b0, 1, "R10 current read after read");

    wr_seq(1'b0, 14'h0FFE, 4, 2'b00, 1'b1, "R4 page wrap write");
    rd_seq(1'b0, 14'h0000, 1'b0, 2, "R10 current read after wrapped write");
    rd_seq(1'b0, 14'h0FC0, 1'b1, 2, "R4 wrapped bytes at page start");

    rd_seq(1'b0, 14'h3FFE, 1'b1, 4, "R9 array wrap read");

    wr_seq(1'b0, 14'h0155, 1, 2'b11, 1'b1, "R3 high bits dropped");
    rd_seq(1'b0, 14'h0155, 1'b1, 1, "R3 read back dropped bits");

    wr_seq(1'b0, 14'h0200, 0, 2'b00, 1'b1, "R5 dummy write");

    // R2: strap and type mismatch
    bus_start();
    send_byte({4'b1010, strap ^ 3'b001, 1'b0}, ack); check(!ack, "R2 strap mismatch nack", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R2 silent after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1001, strap, 1'b1}, ack); check(!ack, "R2 type mismatch nack", ack, 0);
    bus_stop();

    // R1: bytes after stop without a start
    send_byte(sel(1'b0, 1'b0), ack); check(!ack, "R1 no ack without start", ack, 0);
    bus_stop();

    // R11: identification page
    wr_seq(1'b1, 14'h003E, 3, 2'b00, 1'b1, "R11 id write");
    rd_seq(1'b1, 14'h003E, 1'b1, 3, "R11 id read wrap");
    rd_seq(1'b0, 14'h0000, 1'b1, 2, "R11 main untouched");

    // R6: acknowledge polling while busy
    wr_seq(1'b0, 14'h2000, 2, 2'b00, 1'b0, "R6 write before poll");
    nacks = 0;
    ack = 1'b0;
    for (int t = 0; t < 10 && !ack; t++) begin
      bus_start();
      send_byte(sel(1'b0, 1'b0), ack);
      if (!ack) nacks++;
      bus_stop();
    end
    check(nacks >= 1, "R6 nack while busy", nacks, 1);
    check(ack, "R6 ack after busy", ack, 1);
    wait_idle();
    rd_seq(1'b0, 14'h2000, 1'b1, 2, "R6 data after poll");

    wq(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule